// File: doc/BRIEF.md
# Free-Running Compare Timer

This block keeps a 32-bit count that advances on its own, paced only by a
divided tick. The count does not depend on what the processor executes.
Next to the count sits a compare register. When an increment brings the
count onto the compare value, the block raises an interrupt line. That line
feeds a pending bit of the exception unit.

To schedule an event, software reads the count, adds a number of ticks to it
and writes the sum to the compare register. The interrupt stays up until
software writes the compare register again; that rewrite is also the
acknowledge. Software may also write the count, for example to restart it
from zero.

The register port is plain: an address, write data, a write strobe and
combinational read data. No data streams through the block, so there is no
valid/ready handshake and no back-pressure. A write takes effect at the
rising edge on which the strobe is high.

Top module: `tmr_ftimer`

## Requirements
- R1: After reset the count reads 0, the compare register reads all ones, the interrupt is low and the divider phase is zero.
- R2: The count increases by exactly one on every DIV-th clock cycle in which `tick_en` is high, counted since reset; without such pulses the count holds.
- R3: The interrupt rises on the same clock edge on which an increment makes the count equal to the compare value.
- R4: Once raised, the interrupt stays high until a write to the compare register. Such a write clears it, even when the written value equals the current count.
- R5: The count wraps from all ones to zero. The wrap raises no interrupt unless the compare value is zero.
- R6: A write to the count register loads the written value. If an increment is due in the same cycle, the write wins, and that cycle raises no interrupt.
- R7: If a compare write and a matching increment fall on the same edge, the write wins and the interrupt stays low.
- R8: Address 0 selects the count and address 1 selects the compare register. Addresses 2 and 3 read as zero, and writes to them change nothing.
- R9: After the compare register is written with the count plus N, with the divider phase at zero, the interrupt rises after exactly N×DIV tick pulses and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle prescale pulse, further divided by DIV |
| bus_addr | input | AW | Register select (0 count, 1 compare) |
| bus_wdata | input | W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | W | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt to the exception unit |

## Verification
Directed cases schedule a compare at the count plus N. They check that the
line stays low through N×DIV−1 pulses and rises on the last one, which tells
an exact match apart from an early or late one. Further directed cases cover
the collisions: a count write in the same cycle as an increment, and a compare
write in the same cycle as a matching increment. They also cover a wrap past
all ones and accesses to the unused addresses. A seeded random mix follows. It
interleaves tick pulses, idle cycles, count writes near the compare value and
short compare offsets, and after every step it compares the count, the compare
value and the line against a bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned SEL_COUNT = 0;
  localparam int unsigned SEL_CMP   = 1;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic step
);
  generate
    if (DIV <= 1) begin : g_pass
      assign step = tick_en;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;
      assign step = tick_en && (phase_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else if (tick_en) phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count + W'(1);
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> count == $past(count) + W'(1));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !load |=> $stable(count));
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         count_wr,
  input  logic [W-1:0] count,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cmp,
  output logic         irq
);
  logic hit;
  assign hit = step && !count_wr && ((count + W'(1)) == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '1;
      irq <= 1'b0;
    end else begin
      if (cmp_wr) cmp <= cmp_val;
      if (cmp_wr)   irq <= 1'b0;
      else if (hit) irq <= 1'b1;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cmp_wr |=> irq);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !irq);
  assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> count == cmp);
  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !$rose(irq));
endmodule

// File: rtl/tmr_ftimer.sv
module tmr_ftimer #(
  parameter int unsigned W   = 32,
  parameter int unsigned DIV = 4,
  parameter int unsigned AW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);
  import tmr_pkg::*;

  logic         step;
  logic         wr_count;
  logic         wr_cmp;
  logic [W-1:0] count;
  logic [W-1:0] cmp;

  assign wr_count = bus_we && (bus_addr == AW'(SEL_COUNT));
  assign wr_cmp   = bus_we && (bus_addr == AW'(SEL_CMP));

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step(step));

  tmr_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(wr_count),
    .load_val(bus_wdata), .count(count));

  tmr_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .step(step), .count_wr(wr_count),
    .count(count), .cmp_wr(wr_cmp), .cmp_val(bus_wdata), .cmp(cmp), .irq(irq));

  always_comb begin
    if (bus_addr == AW'(SEL_COUNT))    bus_rdata = count;
    else if (bus_addr == AW'(SEL_CMP)) bus_rdata = cmp;
    else                               bus_rdata = '0;
  end
endmodule

// File: tb/tmr_ftimer_bench.sv
module tmr_ftimer_bench;
  localparam int unsigned W = 32;
  localparam int unsigned DIV = 4;
  localparam int unsigned AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [W-1:0] bus_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_count = '0;
  logic [W-1:0] m_cmp = '1;
  logic m_irq = 1'b0;
  int m_phase = 0;

  always #4 clk = ~clk;

  tmr_ftimer #(.W(W), .DIV(DIV), .AW(AW)) u_tmr_ftimer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq));

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model of one cycle; returns nothing, updates model state
  task automatic model_cycle(bit tk, bit we, int adr, logic [W-1:0] d);
    bit st;
    st = 0;
    if (tk) begin
      if (m_phase == DIV - 1) begin st = 1; m_phase = 0; end
      else m_phase++;
    end
    if (we && adr == 0) m_count = d;
    else if (st) begin
      m_count = m_count + 1;
      if (!(we && adr == 1) && m_count == m_cmp) m_irq = 1'b1;
    end
    if (we && adr == 1) begin m_cmp = d; m_irq = 1'b0; end
  endtask

  task automatic cycle(bit tk, bit we, int adr, logic [W-1:0] d);
    @(negedge clk);
    tick_en = tk; bus_we = we; bus_addr = AW'(adr); bus_wdata = d;
    @(posedge clk);
    model_cycle(tk, we, adr, d);
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic read(int adr, output logic [W-1:0] v);
    @(negedge clk);
    bus_addr = AW'(adr);
    #1 v = bus_rdata;
  endtask

  task automatic check_all(string tag);
    logic [W-1:0] v;
    read(0, v); check({tag, " count"}, v, m_count);
    read(1, v); check({tag, " compare"}, v, m_cmp);
    check({tag, " irq"}, W'(irq), W'(m_irq));
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) cycle(1, 0, 0, '0);
  endtask

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    read(0, v); check("R1 count", v, 32'h0);
    read(1, v); check("R1 compare", v, 32'hffff_ffff);
    check("R1 irq", W'(irq), 0);

    // R2 idle cycles do not advance; partial pulses do not either
    repeat (5) cycle(0, 0, 0, '0);
    pulses(DIV - 1);
    check_all("R2 below divide");
    pulses(1);
    check_all("R2 one step");

    // R9 schedule count+3 at phase zero
    cycle(0, 1, 1, m_count + 3);
    pulses(3 * DIV - 1);
    check("R9 not early", W'(irq), 0);
    pulses(1);
    check("R9 exact", W'(irq), 1);
    check_all("R3 match");
    // R4 hold through further ticks, clear by rewrite of same value
    pulses(2 * DIV);
    check("R4 hold", W'(irq), 1);
    cycle(0, 1, 1, m_count);
    check("R4 clear", W'(irq), 0);
    check_all("R4 after clear");

    // R5 wrap, compare away from zero
    cycle(0, 1, 0, 32'hffff_fffe);
    cycle(0, 1, 1, 32'h0000_0010);
    pulses(3 * DIV);
    check_all("R5 wrap");
    check("R5 no event", W'(irq), 0);

    // R6 count write collides with due step that would match
    cycle(0, 1, 0, 32'h100);
    cycle(0, 1, 1, 32'h101);
    pulses(DIV - 1);
    cycle(1, 1, 0, 32'h100);
    check_all("R6 collide");
    check("R6 no irq", W'(irq), 0);

    // R7 compare write collides with matching step
    pulses(DIV - 1);
    cycle(1, 1, 1, 32'h101);
    check_all("R7 collide");
    check("R7 write wins", W'(irq), 0);

    // R8 unused addresses
    cycle(0, 1, 2, 32'hdead_beef);
    cycle(0, 1, 3, 32'hcafe_f00d);
    read(2, v); check("R8 addr2", v, 0);
    read(3, v); check("R8 addr3", v, 0);
    check_all("R8 unchanged");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6)       cycle(1, 0, 0, '0);
      else if (op == 6) cycle(0, 0, 0, '0);
      else if (op == 7) cycle($urandom_range(0, 1), 1, 0, m_cmp - W'($urandom_range(0, 3)));
      else if (op == 8) cycle($urandom_range(0, 1), 1, 1, m_count + W'($urandom_range(0, 4)));
      else              cycle(1, 1, $urandom_range(2, 3), W'($urandom));
      check_all("R2 R4 random");
    end
    finish_run();
  end
endmodule